// File: doc/BRIEF.md
# Multi-Channel Timer Match Status Unit

This block holds a free-running counter and compares it with four programmable match values. On every timer tick the counter steps forward. When a tick arrives while the counter equals a channel's match value, that channel's status flag is raised. The flag stays raised until software clears it. Software clears a flag by writing a one into its bit of the status word. Each channel also drives an interrupt line, which is its flag gated by a per-channel enable bit.

Software reaches the counter, the match values, the status word and the enable mask through a single-cycle register port. The port is addressed by word index. A write takes effect on the clock edge where `reg_we` is high. Read data depends combinationally on `reg_idx`, so a read completes in the same cycle.

Top module: `tmr_match_unit`

## Requirements
- R1: The 32-bit counter increments by one on each clock edge where `tick` is high and wraps from 0xFFFFFFFF to 0. A write to word index 4 loads the counter with the written value, and this load takes precedence over a tick in the same cycle. With neither a tick nor a load, the counter holds its value.
- R2: When `tick` is high at a clock edge and the counter equals the match value of channel i, status bit i becomes 1 at that edge. Channels 0 to 3 occupy status bits 0 to 3 in channel order, and no flag rises before that edge.
- R3: A status flag that is 1 stays 1, across any number of further ticks, until software clears it.
- R4: Writing the status word (word index 5) clears every flag whose bit is 1 in the written data. Flags whose bit is 0 in the written data keep their value.
- R5: If a match event and a clearing write hit the same flag in the same cycle, the flag ends up at 1.
- R6: Bits 31 to 4 of the status word always read as 0, and writing ones to them has no effect.
- R7: Reset (active-low `rst_n`) clears the counter, all match values, all status flags and the enable mask to 0.
- R8: `irq[i]` equals status flag i ANDed with enable bit i. The enable mask is held in bits 3 to 0 of word index 7, and bits 31 to 4 of that word read as 0.
- R9: Writing a match register neither sets nor clears that channel's status flag.
- R10: Word indices 0 to 3 read back match values 0 to 3. Index 4 reads the counter, index 5 the status word and index 7 the enable mask. Every other index reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer tick enable; the counter advances and matches are sampled when high |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Word index of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx` (combinational) |
| irq | output | 4 | Per-channel interrupt, status flag AND enable bit |

## Verification
The assertions check the cycle-level rules on every cycle:
- the counter steps by one or holds, as R1 requires;
- a match event raises its flag, and a raised flag only drops after a clear with no simultaneous match (R2 to R5);
- a match-register write leaves the flag untouched (R9);
- the reserved status bits read as zero (R6);
- no interrupt is raised without its flag (R8).

Some behaviour can only be shown by the bench's scenarios:
- that the flag rises at exactly the tick where the counter equals the match value, and not a tick early, with the counter approaching from several distances on every channel;
- counter wrap-around;
- the full address decode, including the indices that read as zero;
- the interplay of the enable mask with individual clears.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;

  // word indices of the register map (channel match registers occupy 0..NCH-1)
  localparam logic [IDX_W-1:0] IDX_COUNT  = 4'd4;
  localparam logic [IDX_W-1:0] IDX_STATUS = 4'd5;
  localparam logic [IDX_W-1:0] IDX_ENABLE = 4'd7;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  function automatic logic [W-1:0] step(input logic [W-1:0] c);
    return c + {{(W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= step(cnt);
  end

  // R1: one tick moves the counter by exactly one, modulo 2^W
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (cnt - $past(cnt)) == {{(W-1){1'b0}}, 1'b1});
  // R1: idle cycles leave the counter alone
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));
  // R1: a load wins over a tick
  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         match_we,
  input  logic [W-1:0] wdata,
  input  logic         clr,
  output logic [W-1:0] match_q,
  output logic         hit,
  output logic         flag
);
  function automatic logic is_hit(input logic t, input logic [W-1:0] c,
                                  input logic [W-1:0] m);
    return t && (c == m);
  endfunction

  assign hit = is_hit(tick, cnt, match_q);

  always_ff @(posedge clk) begin
    if (!rst_n)        match_q <= '0;
    else if (match_we) match_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R2 / R5: a match event always leaves the flag set, even with a clear
  a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  // R3: a set flag survives any cycle without a clear
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R4: a clear without a concurrent match drops the flag
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);
  // R2: the flag can only rise through a match event
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !hit) |=> !flag);
  // R9: rewriting the match value does not touch the flag
  a_r9_match_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (match_we && !hit && !clr) |=> flag == $past(flag));
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit #(
  parameter int NCH   = 4,
  parameter int CNT_W = tmr_pkg::DATA_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      reg_we,
  input  logic [tmr_pkg::IDX_W-1:0] reg_idx,
  input  logic [tmr_pkg::DATA_W-1:0] reg_wdata,
  output logic [tmr_pkg::DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]            irq
);
  import tmr_pkg::*;

  localparam int PAD_W = DATA_W - NCH;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] match_q [NCH];
  logic [NCH-1:0]   hits;
  logic [NCH-1:0]   flags;
  logic [NCH-1:0]   en_q;

  logic cnt_load, sts_wr, en_wr;
  assign cnt_load = reg_we && (reg_idx == IDX_COUNT);
  assign sts_wr   = reg_we && (reg_idx == IDX_STATUS);
  assign en_wr    = reg_we && (reg_idx == IDX_ENABLE);

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (cnt_load),
    .load_val (reg_wdata[CNT_W-1:0]),
    .cnt      (cnt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic mwe;
    logic clr;
    assign mwe = reg_we && (reg_idx == IDX_W'(g));
    assign clr = sts_wr && reg_wdata[g];
    tmr_chan #(.W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .cnt      (cnt),
      .match_we (mwe),
      .wdata    (reg_wdata[CNT_W-1:0]),
      .clr      (clr),
      .match_q  (match_q[g]),
      .hit      (hits[g]),
      .flag     (flags[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= reg_wdata[NCH-1:0];
  end

  assign irq = flags & en_q;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (reg_idx == IDX_W'(i)) reg_rdata = DATA_W'(match_q[i]);
    case (reg_idx)
      IDX_COUNT:  reg_rdata = DATA_W'(cnt);
      IDX_STATUS: reg_rdata = {{PAD_W{1'b0}}, flags};
      IDX_ENABLE: reg_rdata = {{PAD_W{1'b0}}, en_q};
      default: ;
    endcase
  end

  // R6: reserved status bits never read as one
  a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == IDX_STATUS) |-> reg_rdata[DATA_W-1:NCH] == '0);
  // R8: no interrupt without its status flag
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~flags) == '0);
  // R8: a disabled channel never interrupts
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~en_q) == '0);
endmodule

// File: tb/tb_tmr_match_unit.sv
`timescale 1ns/1ps
module tb_tmr_match_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_match_unit dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam logic [3:0] I_CNT = 4'd4, I_STS = 4'd5, I_EN = 4'd7;

  task automatic cyc(input logic t, input logic we, input logic [3:0] idx,
                     input logic [31:0] d);
    @(negedge clk);
    tick = t; reg_we = we; reg_idx = idx; reg_wdata = d;
    @(posedge clk); #1;
    tick = 1'b0; reg_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 4'd0, 32'd0);
  endtask

  task automatic chk_rd(input logic [3:0] idx, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_idx = idx; #1;
    nchk++;
    if (reg_rdata !== exp) begin
      nerr++;
      $display("FAIL %s idx=%0d actual=%h expected=%h", req, idx, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic [3:0] exp, input string req);
    @(negedge clk); #1;
    nchk++;
    if (irq !== exp) begin
      nerr++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
    end
  endtask

  function automatic logic [31:0] mval(input int k);
    return 32'h100 + 32'(k) * 32'h10;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R7: everything zero after reset
    for (int k = 0; k < 4; k++) chk_rd(4'(k), 32'd0, "R7 match");
    chk_rd(I_CNT, 32'd0, "R7 counter");
    chk_rd(I_STS, 32'd0, "R7 status");
    chk_rd(I_EN,  32'd0, "R7 enable");
    chk_irq(4'd0, "R7 irq");

    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, 4'(k), mval(k));
    for (int k = 0; k < 4; k++) chk_rd(4'(k), mval(k), "R10 match readback");

    // R2 / R1: approach each channel's match from several distances
    for (int ch = 0; ch < 4; ch++) begin
      for (int d = 0; d < 4; d++) begin
        cyc(1'b0, 1'b1, I_CNT, mval(ch) - 32'(d));
        cyc(1'b0, 1'b1, I_STS, 32'hF);
        ticks(d);
        chk_rd(I_STS, 32'd0, "R2 no early flag");
        chk_rd(I_CNT, mval(ch), "R1 count after ticks");
        ticks(1);
        chk_rd(I_STS, 32'd1 << ch, "R2 flag on equality tick");
        chk_rd(I_CNT, mval(ch) + 32'd1, "R1 count step");
      end
      ticks(5);
      chk_rd(I_STS, 32'd1 << ch, "R3 sticky");
    end

    // raise every flag
    for (int ch = 0; ch < 4; ch++) begin
      cyc(1'b0, 1'b1, I_CNT, mval(ch));
      ticks(1);
    end
    chk_rd(I_STS, 32'hF, "R2 all flags");
    cyc(1'b0, 1'b1, I_STS, 32'h0);
    chk_rd(I_STS, 32'hF, "R4 zero write inert");
    cyc(1'b0, 1'b1, I_STS, 32'h5);
    chk_rd(I_STS, 32'hA, "R4 partial clear");
    cyc(1'b0, 1'b1, I_STS, 32'hFFFF_FFF0);
    chk_rd(I_STS, 32'hA, "R6 reserved write inert");
    cyc(1'b0, 1'b1, I_STS, 32'hA);
    chk_rd(I_STS, 32'h0, "R4 full clear");

    // R5: set wins over same-cycle clear
    cyc(1'b0, 1'b1, I_CNT, mval(0));
    cyc(1'b1, 1'b1, I_STS, 32'h1);
    chk_rd(I_STS, 32'h1, "R5 set beats clear");

    // R9: match writes leave the flag alone
    cyc(1'b0, 1'b1, 4'd0, 32'h500);
    chk_rd(I_STS, 32'h1, "R9 flag kept on match write");
    chk_rd(4'd0, 32'h500, "R10 match0 readback");
    cyc(1'b0, 1'b1, I_STS, 32'h1);
    cyc(1'b0, 1'b1, I_CNT, 32'h600);
    cyc(1'b0, 1'b1, 4'd0, 32'h600);
    chk_rd(I_STS, 32'h0, "R9 no set on match write");
    ticks(1);
    chk_rd(I_STS, 32'h1, "R2 match after rewrite");

    // R1: wrap-around, with channel 1 at zero
    cyc(1'b0, 1'b1, 4'd1, 32'h0);
    cyc(1'b0, 1'b1, I_CNT, 32'hFFFF_FFFF);
    cyc(1'b0, 1'b1, I_STS, 32'hF);
    ticks(1);
    chk_rd(I_CNT, 32'h0, "R1 wrap");
    chk_rd(I_STS, 32'h0, "R2 no flag before wrapped tick");
    ticks(1);
    chk_rd(I_STS, 32'h2, "R2 flag after wrap");
    chk_rd(I_CNT, 32'h1, "R1 count after wrap");

    // R8: interrupt gating
    cyc(1'b0, 1'b1, 4'd0, mval(0));
    cyc(1'b0, 1'b1, 4'd1, mval(1));
    for (int ch = 0; ch < 4; ch++) begin
      cyc(1'b0, 1'b1, I_CNT, mval(ch));
      ticks(1);
    end
    chk_irq(4'h0, "R8 irq off while disabled");
    cyc(1'b0, 1'b1, I_EN, 32'hFFFF_FFF5);
    chk_rd(I_EN, 32'h5, "R8 enable readback");
    chk_irq(4'h5, "R8 irq gated");
    cyc(1'b0, 1'b1, I_STS, 32'h1);
    chk_irq(4'h4, "R8 irq follows clear");

    // R10: unused index reads zero
    chk_rd(4'd6, 32'h0, "R10 unused index");
    chk_rd(4'd15, 32'h0, "R10 unused index high");

    // R1: load wins over tick
    cyc(1'b1, 1'b1, I_CNT, 32'h42);
    chk_rd(I_CNT, 32'h42, "R1 load beats tick");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule